// File: doc/BRIEF.md
# Subtract and Negate Flag Generator

This block is a registered arithmetic unit that handles four subtracting operations: subtract-with-extend, compare, negate and negate-with-extend. Each operation works on a byte, word or longword slice of its operands. On each enabled clock edge the block updates a five-bit condition register. The register holds extend, negative, zero, overflow and carry. Every operation except compare also stores a new result.

Multi-word subtraction is built by chaining the extend-form operations. The extend flag from one step feeds the `x_in` input of the next step. The zero flag is sticky for these forms, so it stays set only if every step in the chain gives a zero result. To start a chain, load zero as set first, for example with a compare of two equal values.

Top module: `subneg_flags`

## Requirements
- R1: For subtract-with-extend (`op`=0), the result is dst − src − `x_in` at the selected size. Overflow is set when (src MSB=0, dst MSB=1, result MSB=0) or (src MSB=1, dst MSB=0, result MSB=1). Carry is (Sm·¬Dm)+(Rm·¬Dm)+(Sm·Rm). Compare (`op`=1) computes dst − src with the same overflow and carry rules.
- R2: Flags are packed as `flags_q` = {X, N, Z, V, C}, with X at bit 4 and C at bit 0. N always equals the result MSB at the selected size: bit 7, 15 or 31.
- R3: For subtract-with-extend and negate-with-extend (`op`=3), a nonzero result clears Z and a zero result leaves Z unchanged. For compare and negate, Z is set exactly when the result is zero.
- R4: Negate (`op`=2) computes 0 − dst. Overflow is Dm·Rm and carry is Dm+Rm.
- R5: Negate-with-extend computes 0 − dst − `x_in`, with the negate overflow and carry rules and the sticky Z rule.
- R6: Compare leaves X and `result_q` unchanged. All other operations copy the new C into X.
- R7: `size` codes are 0 for byte, 1 for word, and 2 or 3 for long. Operand bits above the selected size are ignored, and the result's upper bits read as zero.
- R8: When `en` is low, `result_q` and `flags_q` hold their values.
- R9: A synchronous `rst` clears `flags_q` and `result_q` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update strobe |
| op | input | 2 | 0 subtract-with-extend, 1 compare, 2 negate, 3 negate-with-extend |
| size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand |
| x_in | input | 1 | Incoming extend (borrow) |
| result_q | output | 32 | Registered result, zero-extended |
| flags_q | output | 5 | Registered {X, N, Z, V, C} |

## Verification
Some rules are checked by assertions on every cycle:
- reset clears the outputs;
- outputs hold while `en` is low;
- compare preserves X and the result;
- X matches C after every other operation;
- N matches the stored result MSB;
- a cleared Z stays cleared through an extend-form step.

The exact overflow and carry values need the bench's directed scenarios, as do the masking at each size and the sticky-Z behaviour across a chain. These scenarios include both signed-overflow cases, negating the most negative value, and a two-step longword chain.

// File: rtl/subneg_flags.sv
module subneg_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [1:0]   op,
  input  logic [1:0]   size,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic         x_in,
  output logic [W-1:0] result_q,
  output logic [4:0]   flags_q
);
  localparam int FX = 4, FN = 3, FZ = 2, FV = 1, FC = 0;

  function automatic logic [W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = W'(32'h0000_00FF);
      2'd1:    size_mask = W'(32'h0000_FFFF);
      default: size_mask = '1;
    endcase
  endfunction

  function automatic logic top_bit(input logic [W-1:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    top_bit = v[7];
      2'd1:    top_bit = v[15];
      default: top_bit = v[W-1];
    endcase
  endfunction

  logic [W-1:0] mask, s, d, minuend, subtrahend, res;
  logic         is_neg, is_ext, cin, sm, dm, rm, zero_now;
  logic         v_new, c_new, z_new;

  assign mask       = size_mask(size);
  assign s          = src & mask;
  assign d          = dst & mask;
  assign is_neg     = op[1];
  assign is_ext     = (op == 2'd0) || (op == 2'd3);
  assign cin        = is_ext & x_in;
  assign minuend    = is_neg ? '0 : d;
  assign subtrahend = is_neg ? d : s;
  assign res        = (minuend - subtrahend - W'(cin)) & mask;

  assign sm       = top_bit(s, size);
  assign dm       = top_bit(d, size);
  assign rm       = top_bit(res, size);
  assign zero_now = (res == '0);

  assign v_new = is_neg ? (dm & rm) : ((~sm & dm & ~rm) | (sm & ~dm & rm));
  assign c_new = is_neg ? (dm | rm) : ((sm & ~dm) | (rm & ~dm) | (sm & rm));
  assign z_new = is_ext ? (zero_now & flags_q[FZ]) : zero_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q  <= '0;
    end else if (en) begin
      flags_q[FN] <= rm;
      flags_q[FZ] <= z_new;
      flags_q[FV] <= v_new;
      flags_q[FC] <= c_new;
      if (op != 2'd1) begin
        flags_q[FX] <= c_new;
        result_q    <= res;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (flags_q == '0 && result_q == '0)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(flags_q) && $stable(result_q))); // R8
  AST_CMP_KEEPS_X: assert property (@(posedge clk) disable iff (rst)
    (en && op == 2'd1) |=> ($stable(result_q) && $stable(flags_q[FX]))); // R6
  AST_X_FOLLOWS_C: assert property (@(posedge clk) disable iff (rst)
    (en && op != 2'd1) |=> (flags_q[FX] == flags_q[FC])); // R6
  AST_N_IS_MSB: assert property (@(posedge clk) disable iff (rst)
    (en && op != 2'd1) |=> (flags_q[FN] == top_bit(result_q, $past(size)))); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && op != 2'd1) |=> ((result_q & ~size_mask($past(size))) == '0)); // R7
  AST_STICKY_Z: assert property (@(posedge clk) disable iff (rst)
    (en && is_ext && !flags_q[FZ]) |=> !flags_q[FZ]); // R3
endmodule

// File: tb/test_subneg_flags.sv
module test_subneg_flags;
  logic        clk = 0, rst = 1, en = 0, x_in = 0;
  logic [1:0]  op = 0, size = 0;
  logic [31:0] src = 0, dst = 0;
  logic [31:0] result_q;
  logic [4:0]  flags_q;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  subneg_flags i_subneg_flags (.clk(clk), .rst(rst), .en(en), .op(op), .size(size),
    .src(src), .dst(dst), .x_in(x_in), .result_q(result_q), .flags_q(flags_q));

  task automatic check(string req, logic [31:0] er, logic [4:0] ef);
    checks++;
    if (result_q !== er || flags_q !== ef) begin
      errors++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               req, result_q, flags_q, er, ef);
    end
  endtask

  task automatic step(logic [1:0] o, logic [1:0] sz, logic [31:0] s, logic [31:0] d, logic x);
    @(negedge clk);
    op = o; size = sz; src = s; dst = d; x_in = x; en = 1;
    @(negedge clk);
    en = 0;
  endtask

  task automatic t_reset;
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    check("R9 reset", 32'h0, 5'b00000);
  endtask

  task automatic t_negate;
    step(2, 0, 0, 32'h01, 0); check("R4 neg byte 1", 32'hFF, 5'b11001);
    step(2, 0, 0, 32'h80, 0); check("R4 neg byte 0x80", 32'h80, 5'b11011);
    step(2, 1, 0, 32'hABCD0000, 0); check("R7 neg word upper ignored", 32'h0, 5'b00100);
    step(2, 2, 0, 32'h1, 1); check("R4 neg ignores x_in", 32'hFFFFFFFF, 5'b11001);
  endtask

  task automatic t_compare;
    step(1, 2, 32'h5, 32'h5, 0); check("R6 cmp equal keeps X, result", 32'hFFFFFFFF, 5'b10100);
    step(1, 0, 32'h01, 32'h00, 1); check("R1 cmp borrow", 32'hFFFFFFFF, 5'b11001);
  endtask

  task automatic t_subx;
    step(0, 0, 32'hFFFF_FF01, 32'h80, 0); check("R1 subx overflow a", 32'h7F, 5'b00010);
    step(0, 0, 32'hFF, 32'h7F, 0); check("R1 subx overflow b", 32'h80, 5'b11011);
  endtask

  task automatic t_chain;
    step(1, 2, 32'h9, 32'h9, 0); check("R3 chain setup", 32'h80, 5'b10100);
    step(0, 2, 32'h1, 32'h0, 0); check("R3 subx nonzero clears Z", 32'hFFFFFFFF, 5'b11001);
    step(0, 2, 32'h0, 32'h1, 1); check("R3 subx zero keeps cleared Z", 32'h0, 5'b00000);
    step(1, 1, 32'h7, 32'h7, 0); check("R3 setup", 32'h0, 5'b00100);
    step(0, 1, 32'h1233, 32'h1234, 1); check("R3 subx zero keeps set Z", 32'h0, 5'b00100);
  endtask

  task automatic t_negx;
    step(3, 0, 0, 32'h00, 1); check("R5 negx borrow", 32'hFF, 5'b11001);
    step(1, 2, 32'h3, 32'h3, 0); check("R5 setup", 32'hFF, 5'b10100);
    step(3, 2, 0, 32'h0, 0); check("R5 negx zero keeps Z", 32'h0, 5'b00100);
    step(3, 2, 0, 32'h80000000, 0); check("R5 negx min value", 32'h80000000, 5'b11011);
  endtask

  task automatic t_idle;
    @(negedge clk); op = 2; size = 0; dst = 32'h3; en = 0;
    @(negedge clk); @(negedge clk);
    check("R8 idle hold", 32'h80000000, 5'b11011);
    rst = 1; @(negedge clk); rst = 0;
    check("R9 mid-run reset", 32'h0, 5'b00000);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_negate(); t_compare(); t_subx(); t_chain(); t_negx(); t_idle();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule